// File: doc/BRIEF.md
# Non-uniform Segment Address Calculator

This block turns an unsigned fixed-point fraction on [0,1) into the index of a segment in a piecewise table whose segments are narrow at both ends of the range and wide in the middle. Segments double in width from 0 toward one half and halve in width from one half toward 1. A downstream coefficient store uses the index to fetch the piece of a curve that is most non-linear near its ends.

The index is not taken from the top input bits. Two prefix chains run from the most significant bit downward: an OR chain that turns on at the first one bit, and an AND chain that stays on while the bits remain one. The number of asserted chain outputs is the segment index. Bit 0 of the input takes no part. A parameter selects a purely combinational path or one register stage placed between the chains and the counter, and the valid strobe follows the same latency.

With the default 8-bit input there are 14 segments. Indices 0 to 6 cover the lower half and indices 8 to 14 cover the upper half. Index 7 is never produced.

Top module: `nus_seg_addr`

## Requirements
- R1: When input bit W-1 is 0, the index equals (W-1) minus the number of leading zeros counted over bits W-1 down to 1. With W=8 this gives values 0 to 6.
- R2: When input bit W-1 is 1, the index equals (W-1) plus the number of leading ones counted over bits W-1 down to 1. With W=8 this gives values 8 to 14.
- R3: An input whose bits W-1..1 are all zero gives index 0. An input whose bits W-1..1 are all one gives index 2*(W-1), which is 14 for W=8.
- R4: Bit 0 of the input has no effect on the index.
- R5: Segment boundaries lie at raw input values 2^j and 2^W-2^j for 1 <= j <= W-2. The index steps by exactly one when the input crosses each of these values, and it stays constant between them.
- R6: With PIPE=1, out_seg and out_valid follow in_data and in_valid one clock later. With PIPE=0, they follow combinationally.
- R7: The index never exceeds 2*(W-1) and never equals W-1.
- R8: While rst_n is low, out_valid is 0. With PIPE=1, out_seg is also 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only when PIPE=1 |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_data | input | W | Unsigned fraction, MSB weight one half |
| out_valid | output | 1 | Index is valid |
| out_seg | output | $clog2(2*(W-1)+1) | Segment index |

## Verification
The hardest case to reach is the neighbourhood of each power-of-two boundary at both ends of the range, where a one-bit error in a chain moves the index by exactly one. The bench places stimulus at each boundary value and at two below it, so bit 0 stays equal. It also sweeps all input words against a leading-zero and leading-one model. The bench toggles bit 0 on fixed upper bits to show that bit 0 is ignored. It pulses in_valid in isolated and back-to-back patterns, and it runs the registered and combinational variants side by side.

// File: rtl/nus_seg_addr.sv
module nus_seg_addr #(
  parameter int W    = 8,
  parameter int PIPE = 1,
  localparam int NT  = W - 1,
  localparam int AW  = $clog2(2 * NT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  output logic [AW-1:0] out_seg
);

  logic [W-1:1] or_chain, and_chain;
  logic [W-1:1] or_st, and_st;
  logic         vld_st;
  logic         unused_ok;

  assign or_chain[W-1]  = in_data[W-1];
  assign and_chain[W-1] = in_data[W-1];

  for (genvar k = W - 2; k >= 1; k--) begin : g_chain
    assign or_chain[k]  = or_chain[k+1]  | in_data[k];
    assign and_chain[k] = and_chain[k+1] & in_data[k];
  end

  if (PIPE != 0) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        or_st  <= '0;
        and_st <= '0;
        vld_st <= 1'b0;
      end else begin
        or_st  <= or_chain;
        and_st <= and_chain;
        vld_st <= in_valid;
      end
    end
  end else begin : g_comb
    assign or_st  = or_chain;
    assign and_st = and_chain;
    assign vld_st = in_valid & rst_n;
  end

  always_comb begin
    out_seg = '0;
    for (int k = 1; k < W; k++)
      out_seg = out_seg + AW'(or_st[k]) + AW'(and_st[k]);
  end

  assign out_valid = vld_st;
  assign unused_ok = ^{in_data[0], clk, rst_n};

endmodule

module seg_addr_chk #(
  parameter int W    = 8,
  parameter int PIPE = 1,
  localparam int AW  = $clog2(2 * (W - 1) + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_data,
  input logic          out_valid,
  input logic [AW-1:0] out_seg
);

  logic         seen, v_q;
  logic [W-1:0] d_q;
  logic [W-1:0] obs;
  logic         ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
      v_q  <= 1'b0;
      d_q  <= '0;
    end else begin
      seen <= 1'b1;
      v_q  <= in_valid;
      d_q  <= in_data;
    end
  end

  assign obs = (PIPE != 0) ? d_q : in_data;
  assign ok  = (PIPE == 0) || seen;

  // R7
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> (out_seg <= AW'(2 * (W - 1)) && out_seg != AW'(W - 1)));

  // R1
  low_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !obs[W-1]) |-> out_seg <= AW'(W - 2));

  // R2
  high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && obs[W-1]) |-> out_seg >= AW'(W));

  // R3
  zero_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && obs[W-1:1] == '0) |-> out_seg == '0);

  // R3
  top_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && obs[W-1:1] == '1) |-> out_seg == AW'(2 * (W - 1)));

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE != 0 && seen) |-> out_valid == v_q);

  // R8
  always_comb begin
    if (!rst_n && $time > 0)
      reset_quiet_chk: assert (!out_valid);
  end

endmodule

bind nus_seg_addr seg_addr_chk #(.W(W), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .out_valid(out_valid), .out_seg(out_seg)
);

// File: tb/tb_nus_seg_addr.sv
module tb_nus_seg_addr;
  localparam int W  = 8;
  localparam int AW = $clog2(2 * (W - 1) + 1);

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic          out_valid, c_valid;
  logic [AW-1:0] out_seg, c_seg;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nus_seg_addr #(.W(W), .PIPE(1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_seg(out_seg));

  nus_seg_addr #(.W(W), .PIPE(0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(c_valid), .out_seg(c_seg));

  function automatic int ref_seg(input logic [W-1:0] x);
    int run = 0;
    for (int k = W - 1; k >= 1; k--) begin
      if (x[k] != x[W-1]) break;
      run++;
    end
    return x[W-1] ? (W - 1) + run : (W - 1) - run;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [W-1:0] d, input string req, input int exp);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    #1;
    chk({req, " comb seg"}, c_seg, exp);
    chk({req, " comb valid"}, c_valid, v);
    @(negedge clk);
    chk({req, " pipe seg"}, out_seg, exp);
    chk({req, " pipe valid"}, out_valid, v);
  endtask

  task automatic t_reset;
    in_valid = 1'b1;
    in_data  = '1;
    repeat (3) @(negedge clk);
    chk("R8 reset pipe valid", out_valid, 0);
    chk("R8 reset pipe seg", out_seg, 0);
    chk("R8 reset comb valid", c_valid, 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
  endtask

  task automatic t_sweep;
    for (int x = 0; x < (1 << W); x++) begin
      int e = ref_seg(W'(x));
      apply(1'b1, W'(x), x[W-1] ? "R2 sweep" : "R1 sweep", e);
      chk("R7 range", (out_seg <= 2 * (W - 1) && out_seg != W - 1) ? 1 : 0, 1);
    end
  endtask

  task automatic t_ends;
    apply(1'b1, '0, "R3 zero", 0);
    apply(1'b1, W'(1), "R3 lsb only", 0);
    apply(1'b1, '1, "R3 all ones", 2 * (W - 1));
    apply(1'b1, {{(W-1){1'b1}}, 1'b0}, "R3 ones no lsb", 2 * (W - 1));
  endtask

  task automatic t_lsb;
    for (int u = 0; u < (1 << (W - 1)); u += 9) begin
      logic [W-1:0] a = {W'(u)} << 1;
      int e = ref_seg(a);
      apply(1'b1, a, "R4 lsb0", e);
      apply(1'b1, a | W'(1), "R4 lsb1", e);
    end
  endtask

  task automatic t_bounds;
    for (int j = 1; j <= W - 2; j++) begin
      int lo = 1 << j;
      int hi = (1 << W) - (1 << j);
      apply(1'b1, W'(lo - 2), "R5 below low bound", j - 1);
      apply(1'b1, W'(lo), "R5 at low bound", j);
      apply(1'b1, W'(hi - 2), "R5 below high bound", 2 * (W - 1) - j);
      apply(1'b1, W'(hi), "R5 at high bound", 2 * (W - 1) - j + 1);
    end
  endtask

  task automatic t_valid;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h40;
    #1 chk("R6 comb immediate", c_valid, 1);
    @(negedge clk);
    chk("R6 pipe one later valid", out_valid, 1);
    chk("R6 pipe one later seg", out_seg, 6);
    in_valid = 1'b0;
    in_data  = 8'hF0;
    #1 chk("R6 comb drop", c_valid, 0);
    chk("R6 pipe still old seg", out_seg, 6);
    @(negedge clk);
    chk("R6 pipe drop valid", out_valid, 0);
    chk("R6 pipe new seg", out_seg, 11);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_ends();
    t_lsb();
    t_bounds();
    t_valid();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule